// File: doc/BRIEF.md
# Dual-Group Arithmetic Unit with Condition Flags

This block is the execute stage arithmetic of a small 32-bit processor with sixteen registers. A 4-bit operation field from the instruction and one extra opcode bit together form a 5-bit internal operation code. The extra bit selects between a group of two-operand operations and a group of single-operand operations. The second operand comes either from a register or from a 12-bit quick immediate that is sign-extended to 32 bits. The result and its write-enable are combinational. The four condition flags (carry, zero, negative, overflow) are held in a register and updated on the clock edge that ends an arithmetic issue.

The same flag register also accepts two flag-only operations. These OR or AND the low four bits of the immediate into the current flags. An issue-kind input picks one of four actions each cycle: idle, arithmetic, flag-OR or flag-AND. The unit takes one operation every cycle and never stalls, so it has no back-pressure. Operand fetch, register write-back and memory are handled elsewhere.

Flag bit positions in `flags_o` are: bit 3 carry (C), bit 2 zero (Z), bit 1 negative (N), bit 0 overflow (V). The `kind_i` encoding is: 0 idle, 1 arithmetic, 2 flag-OR, 3 flag-AND.

Top module: `alu_flags_unit`

## Requirements
- R1: The internal op is {`grp_i`, `field_i`}. Group 0 codes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 OR, 6 XOR, 7 compare, 8 shift left, 9 logical shift right, 10 arithmetic shift right, 11 unsigned multiply and 12 signed multiply. Group 1 codes are 0 NOT, 1 negate, 2 byte swap, 3 sign-extend byte and 4 sign-extend halfword. Group 1 operations use only operand A.
- R2: Add and add-with-carry give the 32-bit sum, with carry-in taken from the current C for the carry variant. C is the carry out of bit 31. V is set on signed overflow.
- R3: Subtract, subtract-with-borrow and negate set C when a borrow occurs; C is not inverted. Subtract-with-borrow also subtracts the current C. Negate computes 0 − A. V is set on signed overflow.
- R4: Compare updates all four flags exactly as subtract does, and holds `wr_en_o` low.
- R5: AND, OR, XOR, NOT, byte swap, the sign-extends and both multiplies leave C and V at their previous values.
- R6: The shifts take the amount from operand B bits 5..0. C is the last bit shifted out, or 0 for an amount of 0. Amounts of 32 or more give 0 for the logical shifts and a full sign fill for the arithmetic shift. V is cleared.
- R7: The multiplies use bits 15..0 of each operand and return the full 32-bit product, unsigned for code 11 and signed for code 12.
- R8: Byte swap reverses the four bytes. Sign-extend byte copies bit 7 into bits 31..8. Sign-extend halfword copies bit 15 into bits 31..16. NOT inverts all bits.
- R9: With `use_imm_i` high, operand B is `imm_i` sign-extended, so bits 31..12 equal `imm_i[11]`, and `reg_b_i` is ignored.
- R10: Every valid arithmetic operation sets Z when the result is zero and sets N to result bit 31.
- R11: Flag-OR and flag-AND combine `imm_i[3:0]` with the flags. Bits 11..4 of the immediate have no effect.
- R12: Reset clears all flags to 0. An idle cycle leaves the flags unchanged. `wr_en_o` is high only for a valid arithmetic issue that writes a result.
- R13: Unused codes (group 0 codes 13–15, group 1 codes 5–15) drive result 0 with `wr_en_o` low and leave all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kind_i | input | 2 | Issue kind: idle, arithmetic, flag-OR, flag-AND |
| grp_i | input | 1 | Group select: 0 two-operand, 1 single-operand |
| field_i | input | 4 | Operation field within the group |
| use_imm_i | input | 1 | Take operand B from the immediate |
| reg_a_i | input | 32 | Operand A |
| reg_b_i | input | 32 | Register operand B |
| imm_i | input | 12 | Quick immediate; low 4 bits serve the flag operations |
| result_o | output | 32 | Combinational result |
| wr_en_o | output | 1 | Result write-enable |
| flags_o | output | 4 | Registered flags {C, Z, N, V} |

## Verification
The result and the write-enable depend only on the current inputs and the flag register. The bench therefore samples them one time unit after it drives the inputs on the falling edge, in the same cycle. Flags change on the rising edge that ends the issue, so the bench reads them one time unit after that edge, before any new input is applied. Before each table vector, the bench loads a chosen starting flag pattern with a flag-AND of zero followed by a flag-OR. Carry-in and the retained-flag cases then start from a known state.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;
  localparam int FLAG_W = 4;
  localparam int FC = 3;
  localparam int FZ = 2;
  localparam int FN = 1;
  localparam int FV = 0;

  localparam logic [1:0] K_IDLE = 2'd0;
  localparam logic [1:0] K_ALU  = 2'd1;
  localparam logic [1:0] K_FOR  = 2'd2;
  localparam logic [1:0] K_FAND = 2'd3;

  localparam logic [4:0] OP_ADD  = 5'h00;
  localparam logic [4:0] OP_ADC  = 5'h01;
  localparam logic [4:0] OP_SUB  = 5'h02;
  localparam logic [4:0] OP_SBB  = 5'h03;
  localparam logic [4:0] OP_AND  = 5'h04;
  localparam logic [4:0] OP_OR   = 5'h05;
  localparam logic [4:0] OP_XOR  = 5'h06;
  localparam logic [4:0] OP_CMP  = 5'h07;
  localparam logic [4:0] OP_SHL  = 5'h08;
  localparam logic [4:0] OP_SHR  = 5'h09;
  localparam logic [4:0] OP_ASR  = 5'h0A;
  localparam logic [4:0] OP_MULU = 5'h0B;
  localparam logic [4:0] OP_MULS = 5'h0C;
  localparam logic [4:0] OP_NOT  = 5'h10;
  localparam logic [4:0] OP_NEG  = 5'h11;
  localparam logic [4:0] OP_BSW  = 5'h12;
  localparam logic [4:0] OP_SXB  = 5'h13;
  localparam logic [4:0] OP_SXH  = 5'h14;
endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
  parameter int DW = 32,
  parameter int QW = 12
) (
  input  logic          use_imm_i,
  input  logic [DW-1:0] reg_b_i,
  input  logic [QW-1:0] imm_i,
  output logic [DW-1:0] opb_o
);
  logic [DW-1:0] imm_ext;

  generate
    if (DW > QW) begin : g_ext
      assign imm_ext = {{(DW-QW){imm_i[QW-1]}}, imm_i};
    end else begin : g_trunc
      assign imm_ext = imm_i[DW-1:0];
    end
  endgenerate

  assign opb_o = use_imm_i ? imm_ext : reg_b_i;
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_flags_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [4:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  output logic [DW-1:0] res_o,
  output logic          c_o,
  output logic          v_o,
  output logic          cv_upd_o,
  output logic          zn_upd_o,
  output logic          wr_o
);
  localparam int MSB = DW - 1;
  localparam int MW  = DW / 2;
  localparam int SW  = $clog2(DW) + 1;
  localparam int NB  = DW / 8;

  logic [SW-1:0]        amt;
  logic [DW:0]          wide;
  logic signed [DW:0]   sa;
  logic signed [DW-1:0] ma, mb;

  assign amt = b_i[SW-1:0];
  assign sa  = {a_i, 1'b0};
  assign ma  = DW'($signed(a_i[MW-1:0]));
  assign mb  = DW'($signed(b_i[MW-1:0]));

  always_comb begin
    res_o    = '0;
    c_o      = 1'b0;
    v_o      = 1'b0;
    cv_upd_o = 1'b0;
    zn_upd_o = 1'b1;
    wr_o     = 1'b1;
    wide     = '0;
    case (op_i)
      OP_ADD, OP_ADC: begin
        wide     = {1'b0, a_i} + {1'b0, b_i}
                 + {{DW{1'b0}}, (op_i == OP_ADC) & cin_i};
        {c_o, res_o} = wide;
        v_o      = (a_i[MSB] == b_i[MSB]) && (res_o[MSB] != a_i[MSB]);
        cv_upd_o = 1'b1;
      end
      OP_SUB, OP_SBB, OP_CMP: begin
        wide     = {1'b0, a_i} - {1'b0, b_i}
                 - {{DW{1'b0}}, (op_i == OP_SBB) & cin_i};
        {c_o, res_o} = wide;
        v_o      = (a_i[MSB] != b_i[MSB]) && (res_o[MSB] != a_i[MSB]);
        cv_upd_o = 1'b1;
        wr_o     = (op_i != OP_CMP);
      end
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_SHL: begin
        wide     = {1'b0, a_i} << amt;
        {c_o, res_o} = wide;
        cv_upd_o = 1'b1;
      end
      OP_SHR: begin
        wide     = {a_i, 1'b0} >> amt;
        {res_o, c_o} = wide;
        cv_upd_o = 1'b1;
      end
      OP_ASR: begin
        wide     = sa >>> amt;
        {res_o, c_o} = wide;
        cv_upd_o = 1'b1;
      end
      OP_MULU: res_o = DW'(a_i[MW-1:0]) * DW'(b_i[MW-1:0]);
      OP_MULS: res_o = ma * mb;
      OP_NOT:  res_o = ~a_i;
      OP_NEG: begin
        wide     = {(DW+1){1'b0}} - {1'b0, a_i};
        {c_o, res_o} = wide;
        v_o      = a_i[MSB] && res_o[MSB];
        cv_upd_o = 1'b1;
      end
      OP_BSW: begin
        for (int i = 0; i < NB; i++) begin
          res_o[8*i +: 8] = a_i[DW-8-8*i +: 8];
        end
      end
      OP_SXB: res_o = {{(DW-8){a_i[7]}}, a_i[7:0]};
      OP_SXH: res_o = {{(DW-MW){a_i[MW-1]}}, a_i[MW-1:0]};
      default: begin
        zn_upd_o = 1'b0;
        wr_o     = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_flags_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        kind_i,
  input  logic [DW-1:0]     res_i,
  input  logic              c_i,
  input  logic              v_i,
  input  logic              cv_upd_i,
  input  logic              zn_upd_i,
  input  logic [FLAG_W-1:0] imm4_i,
  output logic [FLAG_W-1:0] flags_o
);
  logic [FLAG_W-1:0] nxt;

  always_comb begin
    nxt = flags_o;
    case (kind_i)
      K_ALU: begin
        if (zn_upd_i) begin
          nxt[FZ] = (res_i == '0);
          nxt[FN] = res_i[DW-1];
        end
        if (cv_upd_i) begin
          nxt[FC] = c_i;
          nxt[FV] = v_i;
        end
      end
      K_FOR:   nxt = flags_o | imm4_i;
      K_FAND:  nxt = flags_o & imm4_i;
      default: nxt = flags_o;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags_o <= '0;
    else        flags_o <= nxt;
  end

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    kind_i == K_IDLE |=> $stable(flags_o));
  a_r11_flag_or: assert property (@(posedge clk) disable iff (!rst_n)
    kind_i == K_FOR |=> flags_o == ($past(flags_o) | $past(imm4_i)));
  a_r11_flag_and: assert property (@(posedge clk) disable iff (!rst_n)
    kind_i == K_FAND |=> flags_o == ($past(flags_o) & $past(imm4_i)));
  a_r5_cv_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == K_ALU && !cv_upd_i) |=> (flags_o[FC] == $past(flags_o[FC])
                                        && flags_o[FV] == $past(flags_o[FV])));
  a_r10_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == K_ALU && zn_upd_i) |=> flags_o[FZ] == ($past(res_i) == '0));
  a_r13_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == K_ALU && !zn_upd_i) |=> $stable(flags_o));
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_flags_pkg::*;
#(
  parameter int DW = 32,
  parameter int QW = 12,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    kind_i,
  input  logic          grp_i,
  input  logic [FW-1:0] field_i,
  input  logic          use_imm_i,
  input  logic [DW-1:0] reg_a_i,
  input  logic [DW-1:0] reg_b_i,
  input  logic [QW-1:0] imm_i,
  output logic [DW-1:0] result_o,
  output logic          wr_en_o,
  output logic [3:0]    flags_o
);
  logic [DW-1:0] opb;
  logic [4:0]    op;
  logic          c_n, v_n, cv_upd, zn_upd, core_wr;

  assign op = {grp_i, field_i};

  alu_operand_sel #(.DW(DW), .QW(QW)) u_sel (
    .use_imm_i (use_imm_i),
    .reg_b_i   (reg_b_i),
    .imm_i     (imm_i),
    .opb_o     (opb)
  );

  alu_core #(.DW(DW)) u_core (
    .op_i     (op),
    .a_i      (reg_a_i),
    .b_i      (opb),
    .cin_i    (flags_o[FC]),
    .res_o    (result_o),
    .c_o      (c_n),
    .v_o      (v_n),
    .cv_upd_o (cv_upd),
    .zn_upd_o (zn_upd),
    .wr_o     (core_wr)
  );

  alu_flag_reg #(.DW(DW)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .kind_i   (kind_i),
    .res_i    (result_o),
    .c_i      (c_n),
    .v_i      (v_n),
    .cv_upd_i (cv_upd),
    .zn_upd_i (zn_upd),
    .imm4_i   (imm_i[FLAG_W-1:0]),
    .flags_o  (flags_o)
  );

  assign wr_en_o = (kind_i == K_ALU) && core_wr;

  a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CMP) |-> !wr_en_o);
  a_r12_write_only_alu: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i != K_ALU) |-> !wr_en_o);
  a_r9_imm_sign: assert property (@(posedge clk) disable iff (!rst_n)
    use_imm_i |-> (($countones(opb[DW-1:QW-1]) == 0 || $countones(opb[DW-1:QW-1]) == DW-QW+1)
                   && opb[QW-1] == imm_i[QW-1]));
  a_r13_reserved_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!zn_upd) |-> (!wr_en_o && result_o == '0));
endmodule

// File: tb/tb_alu_flags_unit.sv
module tb_alu_flags_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 34;
  localparam int VW = 123;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  kind = 2'd0;
  logic        grp = 1'b0;
  logic [3:0]  field = 4'd0;
  logic        use_imm = 1'b0;
  logic [31:0] ra = '0, rb = '0;
  logic [11:0] imm = '0;
  logic [31:0] result;
  logic        wr_en;
  logic [3:0]  flags;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_flags_unit dut (
    .clk(clk), .rst_n(rst_n), .kind_i(kind), .grp_i(grp), .field_i(field),
    .use_imm_i(use_imm), .reg_a_i(ra), .reg_b_i(rb), .imm_i(imm),
    .result_o(result), .wr_en_o(wr_en), .flags_o(flags)
  );

  // {grp, field, use_imm, a, b, imm, start flags, result, wr_en, end flags}; flags {C,Z,N,V}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0,4'h0,1'b0,32'h00000001,32'h00000002,12'h000,4'h0,32'h00000003,1'b1,4'h0}, // R2
    {1'b0,4'h0,1'b0,32'h7FFFFFFF,32'h00000001,12'h000,4'h0,32'h80000000,1'b1,4'h3}, // R2
    {1'b0,4'h0,1'b0,32'hFFFFFFFF,32'h00000001,12'h000,4'h0,32'h00000000,1'b1,4'hC}, // R2
    {1'b0,4'h1,1'b0,32'h00000005,32'h00000006,12'h000,4'h8,32'h0000000C,1'b1,4'h0}, // R2
    {1'b0,4'h2,1'b0,32'h00000003,32'h00000005,12'h000,4'h0,32'hFFFFFFFE,1'b1,4'hA}, // R3
    {1'b0,4'h2,1'b0,32'h00000005,32'h00000003,12'h000,4'h8,32'h00000002,1'b1,4'h0}, // R3
    {1'b0,4'h3,1'b0,32'h00000005,32'h00000003,12'h000,4'h8,32'h00000001,1'b1,4'h0}, // R3
    {1'b0,4'h3,1'b0,32'h00000000,32'h00000000,12'h000,4'h8,32'hFFFFFFFF,1'b1,4'hA}, // R3
    {1'b0,4'h2,1'b0,32'h80000000,32'h00000001,12'h000,4'h0,32'h7FFFFFFF,1'b1,4'h1}, // R3
    {1'b0,4'h7,1'b0,32'h00000005,32'h00000005,12'h000,4'h0,32'h00000000,1'b0,4'h4}, // R4
    {1'b0,4'h4,1'b0,32'hF0F0F0F0,32'h0FF0FF00,12'h000,4'h9,32'h00F0F000,1'b1,4'h9}, // R5
    {1'b0,4'h5,1'b0,32'h00000000,32'h00000000,12'h000,4'h9,32'h00000000,1'b1,4'hD}, // R5 R10
    {1'b0,4'h6,1'b0,32'hFFFF0000,32'hFFFFFFFF,12'h000,4'h0,32'h0000FFFF,1'b1,4'h0}, // R5
    {1'b0,4'h8,1'b0,32'h80000001,32'h00000001,12'h000,4'h1,32'h00000002,1'b1,4'h8}, // R6
    {1'b0,4'h9,1'b0,32'h00000003,32'h00000001,12'h000,4'h0,32'h00000001,1'b1,4'h8}, // R6
    {1'b0,4'hA,1'b0,32'h80000000,32'h00000004,12'h000,4'h0,32'hF8000000,1'b1,4'h2}, // R6
    {1'b0,4'h8,1'b0,32'h00000005,32'h00000000,12'h000,4'h8,32'h00000005,1'b1,4'h0}, // R6
    {1'b0,4'h9,1'b0,32'h80000000,32'h00000020,12'h000,4'h0,32'h00000000,1'b1,4'hC}, // R6
    {1'b0,4'hB,1'b0,32'h0000FFFF,32'h0000FFFF,12'h000,4'h9,32'hFFFE0001,1'b1,4'hB}, // R7
    {1'b0,4'hC,1'b0,32'h1234FFFF,32'h00000002,12'h000,4'h0,32'hFFFFFFFE,1'b1,4'h2}, // R7
    {1'b0,4'hC,1'b0,32'h0000FFFF,32'h0000FFFF,12'h000,4'h0,32'h00000001,1'b1,4'h0}, // R7
    {1'b0,4'h0,1'b1,32'h00000010,32'h00000000,12'hFFF,4'h0,32'h0000000F,1'b1,4'h8}, // R9
    {1'b0,4'h0,1'b1,32'h00000000,32'h12345678,12'h800,4'h0,32'hFFFFF800,1'b1,4'h2}, // R9
    {1'b1,4'h0,1'b0,32'h00000000,32'h00000000,12'h000,4'h9,32'hFFFFFFFF,1'b1,4'hB}, // R8 R1
    {1'b1,4'h1,1'b0,32'h00000001,32'h00000000,12'h000,4'h0,32'hFFFFFFFF,1'b1,4'hA}, // R3
    {1'b1,4'h1,1'b0,32'h00000000,32'h00000000,12'h000,4'h0,32'h00000000,1'b1,4'h4}, // R3
    {1'b1,4'h1,1'b0,32'h80000000,32'h00000000,12'h000,4'h0,32'h80000000,1'b1,4'hB}, // R3
    {1'b1,4'h2,1'b0,32'h11223344,32'h00000000,12'h000,4'h0,32'h44332211,1'b1,4'h0}, // R8
    {1'b1,4'h3,1'b0,32'h00000080,32'h00000000,12'h000,4'h0,32'hFFFFFF80,1'b1,4'h2}, // R8
    {1'b1,4'h4,1'b0,32'h12347FFF,32'h00000000,12'h000,4'h0,32'h00007FFF,1'b1,4'h0}, // R8
    {1'b0,4'hD,1'b0,32'h00000005,32'h00000003,12'h000,4'h5,32'h00000000,1'b0,4'h5}, // R13
    {1'b1,4'h7,1'b0,32'h00000005,32'h00000003,12'h000,4'h5,32'h00000000,1'b0,4'h5}, // R13
    {1'b0,4'hA,1'b1,32'hFFFFFF00,32'h00000000,12'h004,4'h0,32'hFFFFFFF0,1'b1,4'h2}, // R6 R9
    {1'b0,4'h7,1'b0,32'h00000003,32'h00000005,12'h000,4'h0,32'hFFFFFFFE,1'b0,4'hA}  // R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic flag_op(input logic [1:0] k, input logic [11:0] v);
    @(negedge clk);
    kind = k; imm = v; use_imm = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic preset(input logic [3:0] f);
    flag_op(2'd3, 12'h000);
    flag_op(2'd2, {8'h00, f});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R12 reset flags", {28'd0, flags}, 32'h0);
    chk("R12 no write in reset idle", {31'd0, wr_en}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      preset(v[40:37]);
      @(negedge clk);
      kind = 2'd1; grp = v[122]; field = v[121:118]; use_imm = v[117];
      ra = v[116:85]; rb = v[84:53]; imm = v[52:41];
      #1;
      chk($sformatf("R1 vec%0d result", i), result, v[36:5]);
      chk($sformatf("R12 vec%0d wr_en", i), {31'd0, wr_en}, {31'd0, v[4]});
      @(posedge clk); #1;
      chk($sformatf("R10 vec%0d flags", i), {28'd0, flags}, {28'd0, v[3:0]});
    end

    // R11: high immediate bits ignored by flag OR / AND; no write
    preset(4'h0);
    flag_op(2'd2, 12'hFF5);
    chk("R11 flag-or", {28'd0, flags}, 32'h5);
    chk("R12 no write on flag op", {31'd0, wr_en}, 32'h0);
    flag_op(2'd3, 12'hFF4);
    chk("R11 flag-and", {28'd0, flags}, 32'h4);
    flag_op(2'd2, 12'hFF8);
    chk("R11 flag-or carry", {28'd0, flags}, 32'hC);

    // R12: idle leaves flags alone even with an arithmetic op on the bus
    @(negedge clk);
    kind = 2'd0; grp = 1'b0; field = 4'h0; ra = 32'hFFFFFFFF; rb = 32'h1; use_imm = 1'b0;
    #1;
    chk("R12 idle no write", {31'd0, wr_en}, 32'h0);
    @(posedge clk); #1;
    chk("R12 idle hold", {28'd0, flags}, 32'hC);

    // R12: reset clears flags again
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    chk("R12 reset clears", {28'd0, flags}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule